// File: doc/BRIEF.md
# Thirty-Cent Drink Controller with Change Return

This block is the control state machine of a single-price drink dispenser. Coins arrive one at a time over a small valid/ready channel. Each coin is a nickel, a dime or a quarter. The controller keeps the running credit in its state. When the credit reaches 30 cents, it pulses a dispense-can strobe for one cycle. It then pays back any overpayment as dime and nickel pulses, one per clock, before it accepts money again. At most one of the three output strobes is high in any cycle.

The credit is held as a state index rather than as an arithmetic register. There is an idle state, ten credit states from 5 to 50 cents, and four return states owing 20, 15, 10 and 5 cents, which makes fifteen states. A parameter stores that index either as a 4-bit binary code or as a 15-bit one-hot vector, with idle on bit 0. A second parameter picks the output style:
- The default Moore form shows the can pulse in the cycle after the coin that completes the price.
- The Mealy form raises it combinationally in the same cycle as that coin and skips the dispense states.

Back-pressure: `coin_ready` is driven from the state alone. A coin transfers only in a cycle where `coin_valid` and `coin_ready` are both high. A source whose coin is not taken must hold `coin_valid` and `coin_type` until it is. `coin_ready` is low in every dispense and change cycle, so coins offered then are not taken and add no credit.

Top module: `vend_change_ctrl`

## Requirements
- R1: A synchronous reset clears the credit to zero, drives all three strobes low and raises `coin_ready`, whatever coin is offered during reset.
- R2: `coin_type` encodes 0 = nickel (5 cents), 1 = dime (10 cents), 2 = quarter (25 cents). A coin transfers when `coin_valid` and `coin_ready` are both high at a rising clock edge.
- R3: In the Moore form, the accepted coin that brings the credit to 30 cents or more is followed by `disp_can` high for exactly one cycle, the cycle after the coin's transfer edge.
- R4: The excess over 30 cents is repaid after the can pulse, in consecutive cycles: first one `disp_dime` pulse for each full 10 cents, then one `disp_nickel` pulse if 5 cents remain.
- R5: No more than one of `disp_can`, `disp_dime` and `disp_nickel` is high in any cycle.
- R6: `coin_ready` is low in every cycle where a dime or nickel is being returned, and in the Moore form also in the can cycle. A coin offered in those cycles is not taken and adds no credit.
- R7: After the last strobe of a sale the controller is idle, with `coin_ready` high and zero credit.
- R8: With `MEALY_OUT` = 1, `disp_can` rises combinationally in the same cycle as the transfer of the coin that completes the price. Change starts in the next cycle.
- R9: The one-hot and binary state storage give identical port behaviour, cycle for cycle.
- R10: Over any coin sequence that ends idle, 30 × cans + 10 × dimes + 5 × nickels returned equals the sum of the values of the accepted coins.
- R11: `coin_type` = 3 is a reserved code. It transfers like a coin but adds no credit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_valid | input | 1 | A coin is offered on `coin_type` |
| coin_type | input | 2 | Coin code: 0 nickel, 1 dime, 2 quarter, 3 reserved |
| coin_ready | output | 1 | Controller can take a coin this cycle |
| disp_can | output | 1 | One-cycle strobe that releases a drink |
| disp_dime | output | 1 | One-cycle strobe that returns a dime |
| disp_nickel | output | 1 | One-cycle strobe that returns a nickel |

## Verification
The bench goes after every overpayment amount (0, 5, 10, 15 and 20 cents), two sales back to back with a coin held during the return phase, a reserved code mid-sequence, and a reset that lands on partial credit. Each failure mode shows up differently:
- A design that credited a refused coin, or credited the reserved code, would dispense at the wrong coin and break the money balance.
- A design that left credit behind after reset would release a can after the first coin of the next sale instead of the third.
- Wrong change sequencing would show as wrong dime or nickel counts, or as two strobes in one cycle.
- An off-by-one in the Moore or Mealy output timing is caught by measuring the gap between the completing coin and the can pulse in both forms.

// File: rtl/vend_pkg.sv
`timescale 1ns/1ps
package vend_pkg;
  // money is counted in units of 5 cents
  localparam int UNIT_CENTS = 5;
  localparam int PRICE_U    = 30 / UNIT_CENTS;
  localparam int NICKEL_U   = 5 / UNIT_CENTS;
  localparam int DIME_U     = 10 / UNIT_CENTS;
  localparam int QUARTER_U  = 25 / UNIT_CENTS;
  // highest credit: one unit short of the price plus the largest coin
  localparam int MAX_U      = PRICE_U - 1 + QUARTER_U;
  localparam int RET_U      = MAX_U - PRICE_U;
  localparam int NUM_ST     = 1 + MAX_U + RET_U;
  localparam int IDX_W      = $clog2(NUM_ST);
  localparam int ADD_W      = $clog2(QUARTER_U + 1);

  // index 0 idle, 1..MAX_U credit in units, then return states from
  // the largest amount owed down to one unit owed
  typedef logic [IDX_W-1:0] st_idx_t;

  typedef enum logic [1:0] {
    COIN_NICKEL  = 2'd0,
    COIN_DIME    = 2'd1,
    COIN_QUARTER = 2'd2,
    COIN_RSVD    = 2'd3
  } coin_e;

  function automatic st_idx_t ret_state(input int owed_u);
    return st_idx_t'(MAX_U + RET_U + 1 - owed_u);
  endfunction

  function automatic int owed_of(input st_idx_t s);
    return MAX_U + RET_U + 1 - int'(s);
  endfunction

  // state entered once a sale of the given credit is released
  function automatic st_idx_t after_sale(input int credit_u);
    int excess;
    excess = credit_u - PRICE_U;
    return (excess <= 0) ? st_idx_t'(0) : ret_state(excess);
  endfunction
endpackage

// File: rtl/vend_coin_accept.sv
`timescale 1ns/1ps
module vend_coin_accept
  import vend_pkg::*;
(
  input  logic             coin_valid,
  input  logic [1:0]       coin_type,
  input  logic             ready,
  output logic             accept,
  output logic [ADD_W-1:0] add_units
);
  assign accept = coin_valid & ready;

  always_comb begin
    unique case (coin_e'(coin_type))
      COIN_NICKEL:  add_units = ADD_W'(NICKEL_U);
      COIN_DIME:    add_units = ADD_W'(DIME_U);
      COIN_QUARTER: add_units = ADD_W'(QUARTER_U);
      default:      add_units = '0;
    endcase
  end
endmodule

// File: rtl/vend_next_logic.sv
`timescale 1ns/1ps
module vend_next_logic
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  st_idx_t          cur,
  input  logic             accept,
  input  logic [ADD_W-1:0] add_units,
  output logic             ready,
  output st_idx_t          nxt,
  output logic             can_o,
  output logic             dime_o,
  output logic             nickel_o
);
  // ready depends on the state alone, so it never waits on the coin
  assign ready = (int'(cur) < PRICE_U);

  always_comb begin
    int sum_u;
    int owed;
    sum_u    = int'(cur) + int'(add_units);
    owed     = owed_of(cur);
    nxt      = cur;
    can_o    = 1'b0;
    dime_o   = 1'b0;
    nickel_o = 1'b0;
    if (int'(cur) < PRICE_U) begin
      if (accept) begin
        if (MEALY_OUT && sum_u >= PRICE_U) begin
          can_o = 1'b1;
          nxt   = after_sale(sum_u);
        end else begin
          nxt = st_idx_t'(sum_u);
        end
      end
    end else if (int'(cur) <= MAX_U) begin
      can_o = 1'b1;
      nxt   = after_sale(int'(cur));
    end else if (int'(cur) < NUM_ST) begin
      if (owed >= DIME_U) begin
        dime_o = 1'b1;
        nxt    = (owed == DIME_U) ? st_idx_t'(0) : ret_state(owed - DIME_U);
      end else begin
        nickel_o = 1'b1;
        nxt      = st_idx_t'(0);
      end
    end else begin
      nxt = st_idx_t'(0);
    end
  end
endmodule

// File: rtl/vend_state_store.sv
`timescale 1ns/1ps
module vend_state_store
  import vend_pkg::*;
#(
  parameter bit ONEHOT_ENC = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  st_idx_t nxt,
  output st_idx_t cur
);
  generate
    if (ONEHOT_ENC) begin : g_onehot
      logic [NUM_ST-1:0] hot_q;
      always_ff @(posedge clk) begin
        if (rst) hot_q <= NUM_ST'(1);
        else     hot_q <= NUM_ST'(1) << nxt;
      end
      always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_ST; i++) begin
          if (hot_q[i]) cur = cur | st_idx_t'(i);
        end
      end
    end else begin : g_binary
      st_idx_t bin_q;
      always_ff @(posedge clk) begin
        if (rst) bin_q <= '0;
        else     bin_q <= nxt;
      end
      assign cur = bin_q;
    end
  endgenerate
endmodule

// File: rtl/vend_change_ctrl.sv
`timescale 1ns/1ps
module vend_change_ctrl
  import vend_pkg::*;
#(
  parameter bit ONEHOT_ENC = 1'b0,
  parameter bit MEALY_OUT  = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coin_valid,
  input  logic [1:0] coin_type,
  output logic       coin_ready,
  output logic       disp_can,
  output logic       disp_dime,
  output logic       disp_nickel
);
  st_idx_t          cur_idx;
  st_idx_t          nxt_idx;
  logic             rdy;
  logic             acc;
  logic [ADD_W-1:0] add_u;

  vend_coin_accept u_coin (
    .coin_valid (coin_valid),
    .coin_type  (coin_type),
    .ready      (rdy),
    .accept     (acc),
    .add_units  (add_u)
  );

  vend_next_logic #(.MEALY_OUT(MEALY_OUT)) u_next (
    .cur       (cur_idx),
    .accept    (acc),
    .add_units (add_u),
    .ready     (rdy),
    .nxt       (nxt_idx),
    .can_o     (disp_can),
    .dime_o    (disp_dime),
    .nickel_o  (disp_nickel)
  );

  vend_state_store #(.ONEHOT_ENC(ONEHOT_ENC)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_idx),
    .cur (cur_idx)
  );

  assign coin_ready = rdy;
endmodule

// File: rtl/vend_change_chk.sv
`timescale 1ns/1ps
module vend_change_chk
  import vend_pkg::*;
#(
  parameter bit MEALY = 1'b0
) (
  input logic    clk,
  input logic    rst,
  input logic    coin_valid,
  input logic    coin_ready,
  input logic    disp_can,
  input logic    disp_dime,
  input logic    disp_nickel,
  input st_idx_t st_idx
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (coin_ready && !disp_can && !disp_dime && !disp_nickel));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({disp_can, disp_dime, disp_nickel}));

  p_can_single_r3: assert property (@(posedge clk) disable iff (rst)
    disp_can |=> !disp_can);

  p_nickel_ends_r7: assert property (@(posedge clk) disable iff (rst)
    disp_nickel |=> (coin_ready && !disp_can && !disp_dime && !disp_nickel));

  p_legal_state_r9: assert property (@(posedge clk) disable iff (rst)
    int'(st_idx) < NUM_ST);

  generate
    if (MEALY) begin : g_mealy
      p_can_with_coin_r8: assert property (@(posedge clk) disable iff (rst)
        disp_can |-> (coin_valid && coin_ready));
      p_change_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (disp_dime || disp_nickel) |-> !coin_ready);
    end else begin : g_moore
      p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (disp_can || disp_dime || disp_nickel) |-> !coin_ready);
      p_can_after_coin_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_can) |-> $past(coin_valid && coin_ready));
    end
  endgenerate
endmodule

bind vend_change_ctrl vend_change_chk #(.MEALY(MEALY_OUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .coin_valid  (coin_valid),
  .coin_ready  (coin_ready),
  .disp_can    (disp_can),
  .disp_dime   (disp_dime),
  .disp_nickel (disp_nickel),
  .st_idx      (cur_idx)
);

// File: tb/tb_vend_change_ctrl.sv
`timescale 1ns/1ps
module tb_vend_change_ctrl;
  typedef logic [1:0] seq_t [8];
  localparam logic [1:0] CN = 2'd0, CD = 2'd1, CQ = 2'd2, CX = 2'd3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic cv  = 1'b0;
  logic [1:0] ct = 2'd0;
  // 0 Moore binary, 1 Moore one-hot, 2 Mealy binary, 3 Mealy one-hot
  logic [3:0] rdy_v, can_v, dim_v, nic_v;

  vend_change_ctrl #(.ONEHOT_ENC(1'b0), .MEALY_OUT(1'b0)) dut (
    .clk(clk), .rst(rst), .coin_valid(cv), .coin_type(ct), .coin_ready(rdy_v[0]),
    .disp_can(can_v[0]), .disp_dime(dim_v[0]), .disp_nickel(nic_v[0]));
  vend_change_ctrl #(.ONEHOT_ENC(1'b1), .MEALY_OUT(1'b0)) dut_moh (
    .clk(clk), .rst(rst), .coin_valid(cv), .coin_type(ct), .coin_ready(rdy_v[1]),
    .disp_can(can_v[1]), .disp_dime(dim_v[1]), .disp_nickel(nic_v[1]));
  vend_change_ctrl #(.ONEHOT_ENC(1'b0), .MEALY_OUT(1'b1)) dut_mly (
    .clk(clk), .rst(rst), .coin_valid(cv), .coin_type(ct), .coin_ready(rdy_v[2]),
    .disp_can(can_v[2]), .disp_dime(dim_v[2]), .disp_nickel(nic_v[2]));
  vend_change_ctrl #(.ONEHOT_ENC(1'b1), .MEALY_OUT(1'b1)) dut_mlyoh (
    .clk(clk), .rst(rst), .coin_valid(cv), .coin_type(ct), .coin_ready(rdy_v[3]),
    .disp_can(can_v[3]), .disp_dime(dim_v[3]), .disp_nickel(nic_v[3]));

  int n_chk = 0, n_fail = 0;
  int base = 0, exp_lat = 1;
  int cyc, last_acc, acc_cnt, first_can_acc;
  int inserted, cans, dimes, nics, rej;
  bit lat_bad, enc_bad, multi;
  logic o_rdy, o_can, o_dim, o_nic;

  function automatic int cents(input logic [1:0] c);
    case (c)
      CN: return 5;
      CD: return 10;
      CQ: return 25;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sample();
    o_rdy = rdy_v[base]; o_can = can_v[base];
    o_dim = dim_v[base]; o_nic = nic_v[base];
    if ({rdy_v[base], can_v[base], dim_v[base], nic_v[base]} !=
        {rdy_v[base+1], can_v[base+1], dim_v[base+1], nic_v[base+1]})
      enc_bad = 1'b1;
  endtask

  // one clock: drive after the falling edge, observe before the rising edge
  task automatic do_cycle(input logic v, input logic [1:0] t, output bit acc);
    @(negedge clk);
    cv = v; ct = t;
    #1;
    sample();
    acc = v && o_rdy;
    if (v && !o_rdy) rej++;
    if (acc) begin
      acc_cnt++;
      last_acc = cyc;
      inserted += cents(t);
    end
    if (32'(o_can) + 32'(o_dim) + 32'(o_nic) > 1) multi = 1'b1;
    if (o_can) begin
      cans++;
      if (first_can_acc < 0) first_can_acc = acc_cnt;
      if (cyc - last_acc != exp_lat) lat_bad = 1'b1;
    end
    if (o_dim) dimes++;
    if (o_nic) nics++;
    cyc++;
  endtask

  // R1: reset with a quarter offered, then check idle state at the ports
  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; cv = 1'b1; ct = CQ;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(!can_v[base] && !dim_v[base] && !nic_v[base], "R1", "strobes in reset",
        32'({can_v[base], dim_v[base], nic_v[base]}), 0);
    chk(rdy_v[base] === 1'b1, "R1", "ready in reset", 32'(rdy_v[base]), 1);
    @(negedge clk);
    rst = 1'b0; cv = 1'b0;
  endtask

  task automatic feed(input logic [1:0] c);
    bit acc;
    int tries;
    acc = 1'b0;
    tries = 0;
    while (!acc && tries < 20) begin
      do_cycle(1'b1, c, acc);
      tries++;
    end
    chk(acc, "R2", "coin taken", 32'(acc), 1);
  endtask

  task automatic run_seq(input string name, input seq_t c, input int n, input bit want_rej);
    int credit, e_cans, e_d, e_n, first_coin, excess;
    bit acc;
    cyc = 0; last_acc = -100; acc_cnt = 0; first_can_acc = -1;
    inserted = 0; cans = 0; dimes = 0; nics = 0; rej = 0;
    lat_bad = 0; enc_bad = 0; multi = 0;
    credit = 0; e_cans = 0; e_d = 0; e_n = 0; first_coin = -1;
    for (int i = 0; i < n; i++) begin
      credit += cents(c[i]);
      if (credit >= 30) begin
        e_cans++;
        if (first_coin < 0) first_coin = i + 1;
        excess = credit - 30;
        e_d += excess / 10;
        e_n += (excess % 10) / 5;
        credit = 0;
      end
    end
    for (int i = 0; i < n; i++) feed(c[i]);
    for (int i = 0; i < 6; i++) do_cycle(1'b0, CN, acc);
    $display("scenario %s mode %0d: cans %0d dimes %0d nickels %0d", name, base, cans, dimes, nics);
    chk(cans == e_cans, "R3", {name, " cans"}, cans, e_cans);
    chk(first_can_acc == first_coin, "R3", {name, " coin that completes price"}, first_can_acc, first_coin);
    chk(dimes == e_d, "R4", {name, " dimes"}, dimes, e_d);
    chk(nics == e_n, "R4", {name, " nickels"}, nics, e_n);
    chk(!multi, "R5", {name, " one strobe per cycle"}, 32'(multi), 0);
    if (base == 0) chk(!lat_bad, "R3", {name, " Moore can timing"}, 32'(lat_bad), 0);
    else           chk(!lat_bad, "R8", {name, " Mealy can timing"}, 32'(lat_bad), 0);
    chk(inserted == 30 * cans + 10 * dimes + 5 * nics, "R10", {name, " money balance"},
        30 * cans + 10 * dimes + 5 * nics, inserted);
    chk(o_rdy === 1'b1 && !o_can && !o_dim && !o_nic, "R7", {name, " idle at end"},
        32'({o_rdy, o_can, o_dim, o_nic}), 8);
    chk(!enc_bad, "R9", {name, " encodings agree"}, 32'(enc_bad), 0);
    if (want_rej) chk(rej > 0, "R6", {name, " coin held off while busy"}, rej, 1);
  endtask

  task automatic t_six_nickels();
    apply_reset(); run_seq("six nickels", '{CN, CN, CN, CN, CN, CN, CN, CN}, 6, 1'b0);
  endtask
  task automatic t_quarter_nickel();
    apply_reset(); run_seq("quarter nickel", '{CQ, CN, CN, CN, CN, CN, CN, CN}, 2, 1'b0);
  endtask
  task automatic t_three_dimes();
    apply_reset(); run_seq("three dimes", '{CD, CD, CD, CN, CN, CN, CN, CN}, 3, 1'b0);
  endtask
  task automatic t_over5();
    apply_reset(); run_seq("35 cents", '{CQ, CD, CN, CN, CN, CN, CN, CN}, 2, 1'b0);
  endtask
  task automatic t_over10();
    apply_reset(); run_seq("40 cents", '{CN, CD, CQ, CN, CN, CN, CN, CN}, 3, 1'b0);
  endtask
  task automatic t_over15();
    apply_reset(); run_seq("45 cents", '{CD, CD, CQ, CN, CN, CN, CN, CN}, 3, 1'b0);
  endtask
  task automatic t_over20();
    apply_reset(); run_seq("50 cents", '{CQ, CQ, CN, CN, CN, CN, CN, CN}, 2, 1'b0);
  endtask
  task automatic t_back_to_back();
    apply_reset(); run_seq("two sales", '{CQ, CQ, CD, CD, CD, CN, CN, CN}, 5, 1'b1);
  endtask
  task automatic t_reserved();
    // R11: reserved code is taken but worth nothing
    apply_reset(); run_seq("reserved code", '{CD, CX, CD, CD, CN, CN, CN, CN}, 4, 1'b0);
  endtask
  task automatic t_reset_mid();
    // R1: credit of 20 cents is wiped by reset
    apply_reset();
    feed(CD);
    feed(CD);
    apply_reset(); run_seq("after reset", '{CD, CD, CD, CN, CN, CN, CN, CN}, 3, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      base = 2 * m;
      exp_lat = (m == 0) ? 1 : 0;
      t_six_nickels();
      t_quarter_nickel();
      t_three_dimes();
      t_over5();
      t_over10();
      t_over15();
      t_over20();
      t_back_to_back();
      t_reserved();
      t_reset_mid();
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule